// File: doc/BRIEF.md
# Binary-to-BCD Seven-Segment Driver

This block takes an unsigned binary word and shows it as three decimal digits: hundreds, tens and units. The conversion is purely combinational. A grid of add-3 correction cells does the work. The shift between grid rows is made by wiring each row one bit higher than the row before, so no register is involved. Each decimal digit then passes through its own BCD-to-segment decoder, which drives one seven-segment digit.

A parameter sets the polarity of the segment outputs. One setting suits displays where a segment lights on logic 0 (common anode). The other suits displays where a segment lights on logic 1 (common cathode). The BCD digits are also brought out, so other logic can use the decimal value directly.

Top module: `bin_bcd_seg_driver`

## Requirements
- R1: `unitsBcd` equals the input value modulo 10, for every input value from 0 to 511.
- R2: `tensBcd` equals the input value divided by 10 (integer division), modulo 10, for every input value from 0 to 511.
- R3: `hundredsBcd` equals the input value divided by 100 (integer division), and it never exceeds 5.
- R4: The add-3 cell returns its 4-bit input unchanged for inputs 0 to 4, and returns the input plus 3 for inputs 5 to 9.
- R5: The add-3 cell returns its input unchanged for the codes 10 to 15.
- R6: Segment vector bit 0 is segment a, bit 1 is b, and so on up to bit 6, which is g. With logic 1 meaning lit, the patterns for digits 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F (hex).
- R7: With `ACTIVE_LOW` = 0 (common cathode), each segment output equals the R6 pattern of its digit.
- R8: With `ACTIVE_LOW` = 1 (common anode), each segment output equals the bitwise inverse of the R6 pattern of its digit.
- R9: A decoder given a code from 10 to 15 lights no segment. Its output is 7'h00 when `ACTIVE_LOW` = 0 and 7'h7F when `ACTIVE_LOW` = 1.
- R10: All outputs depend only on the current input. A new input value shows on every output within the same clock period, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| binIn | input | 9 | Unsigned binary value to display |
| unitsBcd | output | 4 | Units decimal digit |
| tensBcd | output | 4 | Tens decimal digit |
| hundredsBcd | output | 4 | Hundreds decimal digit |
| unitsSeg | output | 7 | Segment drive for the units digit (bit 6..0 = g..a) |
| tensSeg | output | 7 | Segment drive for the tens digit |
| hundredsSeg | output | 7 | Segment drive for the hundreds digit |

## Verification
Every result of this block is due zero cycles after its stimulus, because no register lies between the input and any output. The bench changes the input just after a rising edge of its clock. It reads all six outputs at the following falling edge, half a period later, once the add-3 grid and the decoders have settled. The add-3 cell and the segment decoder are also driven on their own. This reaches input codes 10 to 15, which the full path can never produce, and it covers both settings of the polarity parameter.

// File: rtl/bcd_seg_pkg.sv
package bcd_seg_pkg;
  localparam int DIGIT_W = 4;
  localparam int SEG_W   = 7;

  typedef logic [DIGIT_W-1:0] bcdDigit_t;
  typedef logic [SEG_W-1:0]   segVec_t;
endpackage

// File: rtl/bcd_add3_cell.sv
module bcd_add3_cell
  import bcd_seg_pkg::*;
(
  input  bcdDigit_t cellIn,
  output bcdDigit_t cellOut
);
  always_comb begin
    if (cellIn >= 4'd5 && cellIn <= 4'd9) cellOut = cellIn + 4'd3;
    else                                  cellOut = cellIn;
  end

  // R4: a valid digit never comes out in the range 5..7
  always_comb begin
    if (cellIn <= 4'd9)
      a_r4_no_mid_output: assert (!(cellOut inside {4'd5, 4'd6, 4'd7}))
        else $error("add-3 cell produced %0d from %0d", cellOut, cellIn);
  end
endmodule

// File: rtl/bcd_shift_array.sv
module bcd_shift_array
  import bcd_seg_pkg::*;
#(
  parameter int BIN_W  = 9,
  parameter int DIGITS = 3
) (
  input  logic [BIN_W-1:0]              binVal,
  output logic [DIGITS-1:0][DIGIT_W-1:0] bcdVal
);
  localparam int TOT_W = DIGITS * DIGIT_W + BIN_W;

  logic [BIN_W:0][TOT_W-1:0]                stageVal;
  logic [BIN_W-1:0][DIGITS-1:0][DIGIT_W-1:0] digCorr;
  logic unusedLowBits;

  assign stageVal[0] = {{(DIGITS*DIGIT_W){1'b0}}, binVal};

  for (genvar s = 0; s < BIN_W; s++) begin : gStage
    for (genvar d = 0; d < DIGITS; d++) begin : gDigit
      bcd_add3_cell uCell (
        .cellIn (stageVal[s][BIN_W + DIGIT_W*d +: DIGIT_W]),
        .cellOut(digCorr[s][d])
      );
    end
    // The shift is wiring: the next row sits one bit higher.
    assign stageVal[s+1] = {digCorr[s], stageVal[s][BIN_W-1:0]} << 1;
  end

  assign bcdVal        = stageVal[BIN_W][TOT_W-1:BIN_W];
  assign unusedLowBits = ^stageVal[BIN_W][BIN_W-1:0];

  // R1/R2: every produced digit is a legal decimal digit
  // R3: top digit bounded by the largest 9-bit value
  always_comb begin
    for (int d = 0; d < DIGITS; d++)
      a_r1_digit_legal: assert (bcdVal[d] <= 4'd9)
        else $error("digit %0d out of range: %0d", d, bcdVal[d]);
    if (BIN_W == 9 && DIGITS == 3)
      a_r3_hundreds_max: assert (bcdVal[2] <= 4'd5)
        else $error("hundreds digit %0d exceeds 5", bcdVal[2]);
  end
endmodule

// File: rtl/bcd_seg_decoder.sv
module bcd_seg_decoder
  import bcd_seg_pkg::*;
#(
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  bcdDigit_t digitIn,
  output segVec_t   segOut
);
  segVec_t litPattern;
  segVec_t litView;

  always_comb begin
    unique case (digitIn)
      4'd0:    litPattern = 7'h3F;
      4'd1:    litPattern = 7'h06;
      4'd2:    litPattern = 7'h5B;
      4'd3:    litPattern = 7'h4F;
      4'd4:    litPattern = 7'h66;
      4'd5:    litPattern = 7'h6D;
      4'd6:    litPattern = 7'h7D;
      4'd7:    litPattern = 7'h07;
      4'd8:    litPattern = 7'h7F;
      4'd9:    litPattern = 7'h6F;
      default: litPattern = 7'h00;
    endcase
  end

  if (ACTIVE_LOW) begin : gAnode
    assign segOut = ~litPattern;
  end else begin : gCathode
    assign segOut = litPattern;
  end

  assign litView = ACTIVE_LOW ? ~segOut : segOut;

  always_comb begin
    if (digitIn > 4'd9)
      a_r9_blank_level: assert (segOut == {SEG_W{ACTIVE_LOW}})
        else $error("code %0d not blanked: %h", digitIn, segOut);
    else
      a_r6_min_lit: assert ($countones(litView) >= 2)
        else $error("digit %0d lights too few segments", digitIn);
  end
endmodule

// File: rtl/bin_bcd_seg_driver.sv
module bin_bcd_seg_driver
  import bcd_seg_pkg::*;
#(
  parameter int BIN_W      = 9,
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  logic [BIN_W-1:0]   binIn,
  output logic [DIGIT_W-1:0] unitsBcd,
  output logic [DIGIT_W-1:0] tensBcd,
  output logic [DIGIT_W-1:0] hundredsBcd,
  output logic [SEG_W-1:0]   unitsSeg,
  output logic [SEG_W-1:0]   tensSeg,
  output logic [SEG_W-1:0]   hundredsSeg
);
  localparam int DIGITS = 3;

  logic [DIGITS-1:0][DIGIT_W-1:0] bcdAll;
  logic [DIGITS-1:0][SEG_W-1:0]   segAll;

  bcd_shift_array #(.BIN_W(BIN_W), .DIGITS(DIGITS)) uArray (
    .binVal(binIn),
    .bcdVal(bcdAll)
  );

  for (genvar d = 0; d < DIGITS; d++) begin : gDec
    bcd_seg_decoder #(.ACTIVE_LOW(ACTIVE_LOW)) uDec (
      .digitIn(bcdAll[d]),
      .segOut (segAll[d])
    );
  end

  assign unitsBcd    = bcdAll[0];
  assign tensBcd     = bcdAll[1];
  assign hundredsBcd = bcdAll[2];
  assign unitsSeg    = segAll[0];
  assign tensSeg     = segAll[1];
  assign hundredsSeg = segAll[2];
endmodule

// File: tb/bin_bcd_seg_driver_test.sv
module bin_bcd_seg_driver_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int failures = 0;

  logic [8:0] binIn;
  logic [3:0] uA, tA, hA, uC, tC, hC;
  logic [6:0] usA, tsA, hsA, usC, tsC, hsC;
  logic [3:0] cellIn, cellOut, decIn;
  logic [6:0] decLowOut, decHighOut;

  bin_bcd_seg_driver #(.ACTIVE_LOW(1'b1)) uut (
    .binIn(binIn), .unitsBcd(uA), .tensBcd(tA), .hundredsBcd(hA),
    .unitsSeg(usA), .tensSeg(tsA), .hundredsSeg(hsA));
  bin_bcd_seg_driver #(.ACTIVE_LOW(1'b0)) uutCc (
    .binIn(binIn), .unitsBcd(uC), .tensBcd(tC), .hundredsBcd(hC),
    .unitsSeg(usC), .tensSeg(tsC), .hundredsSeg(hsC));
  bcd_add3_cell cellProbe (.cellIn(cellIn), .cellOut(cellOut));
  bcd_seg_decoder #(.ACTIVE_LOW(1'b1)) decLow  (.digitIn(decIn), .segOut(decLowOut));
  bcd_seg_decoder #(.ACTIVE_LOW(1'b0)) decHigh (.digitIn(decIn), .segOut(decHighOut));

  function automatic logic [6:0] refSeg(int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F; default: return 7'h00;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic applyBin(int v);
    @(posedge clk);
    binIn = v[8:0];
    @(negedge clk);
  endtask

  task automatic checkValue(int v);
    int u = v % 10, t = (v / 10) % 10, h = v / 100;
    check($sformatf("R1 units v=%0d", v), uA, u);
    check($sformatf("R2 tens v=%0d", v), tA, t);
    check($sformatf("R3 hundreds v=%0d", v), hA, h);
    check($sformatf("R1 units cc v=%0d", v), uC, u);
    check($sformatf("R8 anode units v=%0d", v), usA, ~refSeg(u) & 7'h7F);
    check($sformatf("R8 anode tens v=%0d", v), tsA, ~refSeg(t) & 7'h7F);
    check($sformatf("R8 anode hundreds v=%0d", v), hsA, ~refSeg(h) & 7'h7F);
    check($sformatf("R7 cathode units v=%0d", v), usC, refSeg(u));
    check($sformatf("R7 cathode tens v=%0d", v), tsC, refSeg(t));
    check($sformatf("R7 cathode hundreds v=%0d", v), hsC, refSeg(h));
  endtask

  task automatic testFirstValue();
    applyBin(0);
    checkValue(0);
    check("R6 zero pattern a..f lit", usC, 7'h3F);
  endtask

  task automatic testBoundaries();
    int pts[10] = '{9, 10, 99, 100, 199, 200, 255, 256, 500, 511};
    foreach (pts[i]) begin
      applyBin(pts[i]);
      checkValue(pts[i]);
    end
    check("R3 hundreds at 511 is 5", hA, 5);
  endtask

  task automatic testSweep();
    for (int v = 0; v < 512; v++) begin
      applyBin(v);
      checkValue(v);
    end
  endtask

  task automatic testR10Sameperiod();
    applyBin(123);
    check("R10 units within period", uA, 3);
    applyBin(456);
    check("R10 hundreds within period", hA, 4);
  endtask

  task automatic testCell();
    for (int c = 0; c < 16; c++) begin
      @(posedge clk);
      cellIn = c[3:0];
      @(negedge clk);
      if (c >= 5 && c <= 9) check($sformatf("R4 cell in=%0d", c), cellOut, c + 3);
      else if (c < 5)       check($sformatf("R4 cell in=%0d", c), cellOut, c);
      else                  check($sformatf("R5 cell in=%0d", c), cellOut, c);
    end
  endtask

  task automatic testDecoder();
    for (int c = 0; c < 16; c++) begin
      @(posedge clk);
      decIn = c[3:0];
      @(negedge clk);
      if (c <= 9) begin
        check($sformatf("R6 R7 decoder in=%0d", c), decHighOut, refSeg(c));
        check($sformatf("R8 decoder in=%0d", c), decLowOut, ~refSeg(c) & 7'h7F);
      end else begin
        check($sformatf("R9 blank high in=%0d", c), decHighOut, 7'h00);
        check($sformatf("R9 blank low in=%0d", c), decLowOut, 7'h7F);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    binIn = '0;
    cellIn = '0;
    decIn = '0;
    testFirstValue();
    testBoundaries();
    testR10Sameperiod();
    testSweep();
    testCell();
    testDecoder();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule